// File: doc/BRIEF.md
# Conversion Trigger Source Selector

This block sits in front of a converter's sequencing logic and decides when a new conversion starts. A select field picks one of several single-bit event flags: the conversion-complete flag for free-running operation, or one of six external event flags (comparator, external interrupt, compare match A, timer overflow, compare match B, pin change). A rising edge of the chosen signal becomes a one-cycle start pulse. A direct software start request shares the same output.

The edge detector looks at the output of the source multiplexer, not at each flag on its own. Moving the selection from a source that reads 0 to one that reads 1 therefore counts as an edge. The one exception is a move into free-running mode, which never produces a trigger. Triggers that arrive while a conversion is busy are dropped, not held. The reset is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `adc_trig_sel`

## Requirements
- R1: While reset is asserted, and right after it is released, `start_o` is 0. Asserting reset forces `start_o` to 0 at once, without waiting for a clock edge.
- R2: With `auto_en_i`=1, `conv_en_i`=1 and `busy_i`=0, a 0-to-1 change on the selected event flag gives `start_o`=1 in the next cycle. The select codes are: 1 = `evt_i[0]` comparator, 2 = `evt_i[1]` external interrupt, 3 = `evt_i[2]` compare match A, 4 = `evt_i[3]` overflow, 5 = `evt_i[4]` compare match B, 6 = `evt_i[5]` pin change.
- R3: Event flags that are not selected have no effect on `start_o`.
- R4: While `auto_en_i`=0, no flag, select code or select change produces a pulse.
- R5: Changing `sel_i` from a source that reads 0 to a source that reads 1 produces one pulse. Changing between two sources that both read 1 produces none.
- R6: While `conv_en_i`=0, `start_o` stays 0, even when an edge or a software request is present.
- R7: Changing `sel_i` to 0 (free-running) never produces a pulse, even when `conv_done_i`=1. Holding that flag at 1 afterwards does not produce a late pulse.
- R8: With `sel_i`=0 and `sel_i` unchanged, a rising edge of `conv_done_i` starts the next conversion.
- R9: Select code 7 is reserved and never produces a pulse.
- R10: A trigger edge that arrives while `busy_i`=1 is dropped. It does not produce a pulse after `busy_i` falls.
- R11: `sw_start_i`=1 gives a pulse in the next cycle when `conv_en_i`=1 and `busy_i`=0, whatever `auto_en_i` is. The request is ignored when `conv_en_i`=0 or `busy_i`=1.
- R12: A flag held at 1 gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | SEL_W (3) | Trigger source select code |
| auto_en_i | input | 1 | Auto-trigger enable |
| conv_en_i | input | 1 | Converter enabled |
| busy_i | input | 1 | Conversion in progress |
| sw_start_i | input | 1 | Software start request |
| conv_done_i | input | 1 | Conversion-complete flag (free-running source) |
| evt_i | input | NUM_EVT (6) | External event flags |
| start_o | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions assume that the event flags, `conv_done_i` and `sel_i` are steady between clock edges. They also assume that `sw_start_i` is a deliberate per-cycle request, so that holding it high may legitimately give back-to-back pulses. The free-running checks also depend on the previous cycle's select value being valid, so they wait one cycle after the internal reset is released. The stimulus changes inputs only at falling clock edges, keeps `sw_start_i` low in every step that checks for a suppressed trigger, and keeps each flag high for at least one full cycle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // select code used for free-running operation
  localparam int unsigned FREE_RUN_CODE = 0;

  function automatic int unsigned sel_width(input int unsigned n_evt);
    return $clog2(n_evt + 2);
  endfunction
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int unsigned NUM_EVT = 6,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               conv_done_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               trig_o
);
  import adc_trig_pkg::*;

  logic [NUM_EVT-1:0] hit;

  // code c (1..NUM_EVT) selects event flag c-1; codes above that are reserved
  for (genvar c = 1; c <= NUM_EVT; c++) begin : g_src
    assign hit[c-1] = (sel_i == SEL_W'(c)) & evt_i[c-1];
  end

  always_comb begin
    if (sel_i == SEL_W'(FREE_RUN_CODE)) begin
      trig_o = conv_done_i;
    end else begin
      trig_o = |hit;
    end
  end
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             trig_i,
  output logic             rise_o,
  output logic             fr_switch_o
);
  import adc_trig_pkg::*;

  logic             prev_q, prev_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  // the previous value follows the muxed signal every cycle
  always_comb begin
    prev_d = trig_i;
    sel_d  = sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= SEL_W'(FREE_RUN_CODE);
    end else begin
      prev_q <= prev_d;
      sel_q  <= sel_d;
    end
  end

  assign rise_o      = trig_i & ~prev_q;
  assign fr_switch_o = (sel_i == SEL_W'(FREE_RUN_CODE)) &&
                       (sel_q != SEL_W'(FREE_RUN_CODE));
endmodule

// File: rtl/trig_start_gate.sv
module trig_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en_i,
  input  logic conv_en_i,
  input  logic busy_i,
  input  logic sw_start_i,
  input  logic rise_i,
  input  logic fr_switch_i,
  output logic start_o
);
  logic start_q, start_d;
  logic auto_hit;

  always_comb begin
    auto_hit = auto_en_i & rise_i & ~fr_switch_i;
    start_d  = conv_en_i & ~busy_i & (sw_start_i | auto_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int unsigned NUM_EVT = 6,
  parameter int unsigned SEL_W   = adc_trig_pkg::sel_width(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               auto_en_i,
  input  logic               conv_en_i,
  input  logic               busy_i,
  input  logic               sw_start_i,
  input  logic               conv_done_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               start_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       trig, rise, fr_switch;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  trig_src_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_mux (
    .sel_i       (sel_i),
    .conv_done_i (conv_done_i),
    .evt_i       (evt_i),
    .trig_o      (trig)
  );

  trig_edge_det #(.SEL_W(SEL_W)) u_edge (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sel_i       (sel_i),
    .trig_i      (trig),
    .rise_o      (rise),
    .fr_switch_o (fr_switch)
  );

  trig_start_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .auto_en_i   (auto_en_i),
    .conv_en_i   (conv_en_i),
    .busy_i      (busy_i),
    .sw_start_i  (sw_start_i),
    .rise_i      (rise),
    .fr_switch_i (fr_switch),
    .start_o     (start_o)
  );
endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel_i,
  input logic             auto_en_i,
  input logic             conv_en_i,
  input logic             busy_i,
  input logic             sw_start_i,
  input logic             conv_done_i,
  input logic             start_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_auto_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en_i && !sw_start_i) |=> !start_o);

  p_conv_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en_i |=> !start_o);

  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !start_o);

  p_sw_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_start_i && conv_en_i && !busy_i) |=> start_o);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '1 && !sw_start_i) |=> !start_o);

  p_fr_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sel_i == '0 && $past(sel_i) != '0 && !sw_start_i) |=> !start_o);

  p_fr_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sel_i == '0 && $past(sel_i) == '0 && auto_en_i && conv_en_i &&
     !busy_i && conv_done_i && !$past(conv_done_i)) |=> start_o);
endmodule

bind adc_trig_sel adc_trig_sel_chk #(.SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sel_i       (sel_i),
  .auto_en_i   (auto_en_i),
  .conv_en_i   (conv_en_i),
  .busy_i      (busy_i),
  .sw_start_i  (sw_start_i),
  .conv_done_i (conv_done_i),
  .start_o     (start_o)
);

// File: tb/adc_trig_sel_tb.sv
module adc_trig_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel;
  logic       auto_en, conv_en, busy, sw_start, conv_done;
  logic [5:0] evt;
  logic       start;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  adc_trig_sel u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .auto_en_i(auto_en),
    .conv_en_i(conv_en), .busy_i(busy), .sw_start_i(sw_start),
    .conv_done_i(conv_done), .evt_i(evt), .start_o(start)
  );

  // {sel, auto, conv_en, busy, sw, done, evt[5:0], expected start}
  localparam int NV = 28;
  localparam logic [14:0] VEC [NV] = '{
    {3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000001,1'b1}, // R2
    {3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000001,1'b0}, // R12
    {3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd1,1'b1,1'b1,1'b0,1'b0,1'b0,6'b001000,1'b0}, // R3
    {3'd4,1'b1,1'b1,1'b0,1'b0,1'b0,6'b001000,1'b1}, // R5
    {3'd4,1'b1,1'b1,1'b0,1'b0,1'b0,6'b001000,1'b0}, // R12
    {3'd4,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,6'b000010,1'b0}, // R4
    {3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd2,1'b1,1'b0,1'b0,1'b0,1'b0,6'b000010,1'b0}, // R6
    {3'd2,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd7,1'b1,1'b1,1'b0,1'b0,1'b0,6'b111111,1'b0}, // R9
    {3'd7,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd0,1'b1,1'b1,1'b0,1'b0,1'b1,6'b000000,1'b0}, // R7
    {3'd0,1'b1,1'b1,1'b0,1'b0,1'b1,6'b000000,1'b0}, // R7
    {3'd0,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd0,1'b1,1'b1,1'b0,1'b0,1'b1,6'b000000,1'b1}, // R8
    {3'd0,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd6,1'b1,1'b1,1'b1,1'b0,1'b0,6'b100000,1'b0}, // R10
    {3'd6,1'b1,1'b1,1'b0,1'b0,1'b0,6'b100000,1'b0}, // R10
    {3'd6,1'b1,1'b1,1'b0,1'b1,1'b0,6'b000000,1'b1}, // R11
    {3'd6,1'b1,1'b0,1'b0,1'b1,1'b0,6'b000000,1'b0}, // R11
    {3'd6,1'b1,1'b1,1'b1,1'b1,1'b0,6'b000000,1'b0}, // R11
    {3'd3,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000100,1'b1}, // R2
    {3'd5,1'b1,1'b1,1'b0,1'b0,1'b0,6'b010100,1'b0}, // R5
    {3'd5,1'b1,1'b1,1'b0,1'b0,1'b0,6'b000000,1'b0},
    {3'd6,1'b1,1'b1,1'b0,1'b0,1'b0,6'b100000,1'b1}  // R2
  };

  function automatic string req_of(input int i);
    case (i)
      1, 24, 27: return "R2";
      2, 6:      return "R12";
      4:         return "R3";
      5, 25:     return "R5";
      8:         return "R4";
      10:        return "R6";
      12:        return "R9";
      14, 15:    return "R7";
      17:        return "R8";
      19, 20:    return "R10";
      21, 22, 23: return "R11";
      default:   return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (start !== exp) begin
      errors++;
      $display("FAIL %s: start_o=%b expected %b at %0t", req, start, exp, $time);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 3'd0; auto_en = 1'b0; conv_en = 1'b0; busy = 1'b0;
    sw_start = 1'b0; conv_done = 1'b0; evt = 6'b0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      {sel, auto_en, conv_en, busy, sw_start, conv_done, evt} = VEC[i][14:1];
      @(posedge clk);
      @(negedge clk);
      check(req_of(i), VEC[i][0]);
    end

    // R12: free-running flag held high -> one pulse only
    sel = 3'd0; auto_en = 1'b1; conv_en = 1'b1; busy = 1'b0; evt = 6'b0;
    conv_done = 1'b0; sw_start = 1'b0;
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk); check("R8", 1'b1);
    @(negedge clk); check("R12", 1'b0);
    @(negedge clk); check("R12", 1'b0);
    conv_done = 1'b0;
    @(negedge clk);

    // R1: asynchronous reset clears a live pulse without a clock edge
    sel = 3'd1; evt = 6'b000001;
    @(posedge clk); #2;
    check("R2", 1'b1);
    rst_n = 1'b0; #1;
    check("R1", 1'b0);
    @(negedge clk); check("R1", 1'b0);
    evt = 6'b0; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 1'b0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule